// File: doc/BRIEF.md
# Auto-ranging error sample scaler

This block sits between a small flash converter that digitises a loop error and the digital compensator that consumes it. Each time the PWM timing logic raises a sample request, the block takes the 6-bit raw code and scales it by a shift chosen from a two-bit gain setting. The result is an error word whose weight is fixed at 1 LSB per mV, whatever the gain. It registers that word and raises a one-cycle strobe for the compensator.

The gain setting can be loaded by software. It can also be left to an automatic mode, which looks at each sample and moves the setting one step for the next sample. The aim is the finest resolution that still holds the signal. Two optional transforms act on the scaled error: a polarity flip, and an absolute mode that adds the set-point reference. The set-point reference has a 10-bit integer part and a 4-bit fraction. The fraction is realised by dithering the integer part over a 16-sample frame.

Top module: `err_autorange`

## Requirements
- R1: After reset `err_word` is 0, `err_valid` is 0 and `gain_cur` is 0.
- R2: A cycle with `sample_req` high makes `err_valid` high for exactly the next cycle and updates `err_word` in that cycle. Without a request, `err_valid` is low and `err_word` holds its value.
- R3: The raw code is a 6-bit two's complement value (-32..+31). With `invert` and `abs_mode` low, `err_word` is the signed 12-bit value raw × 2^(3−g), where g is the gain setting in force when the request arrives. Gains 3, 2, 1 and 0 therefore give steps of 1, 2, 4 and 8, and gain 0 spans -256..+248.
- R4: `gain_wr` loads `gain_wdata` into the gain setting on the next cycle. When a write and an automatic update meet in the same cycle, the write wins.
- R5: With `auto_en` low, samples never change the gain setting.
- R6: With `auto_en` high, each sample updates the gain setting used by the next sample. A raw code of -32 or +31 lowers it by one, with a floor of 0. A raw code in -15..+15 raises it by one, with a ceiling of 3. Any other code leaves it unchanged.
- R7: With `invert` high, the scaled error is negated before any set-point addition. This can give +256.
- R8: With `abs_mode` high, the dithered set-point is added to the (possibly negated) scaled error.
- R9: Let n be the number of samples since reset, taken modulo 16. The dithered set-point is `ref_int` + 1 when the 4-bit bit-reversal of n is below `ref_frac`, and `ref_int` otherwise. Over any 16 consecutive samples, exactly `ref_frac` of them are incremented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_req | input | 1 | Sample request from PWM timing |
| raw_code | input | 6 | Raw converter code, two's complement |
| auto_en | input | 1 | Enables automatic gain selection |
| gain_wr | input | 1 | Software gain write strobe |
| gain_wdata | input | 2 | Gain value to write |
| invert | input | 1 | Negates the error |
| abs_mode | input | 1 | Adds the dithered set-point to the error |
| ref_int | input | 10 | Set-point integer part |
| ref_frac | input | 4 | Set-point dither fraction |
| err_word | output | 12 | Scaled signed error word |
| err_valid | output | 1 | One-cycle strobe to the compensator |
| gain_cur | output | 2 | Gain setting in force |

## Verification
Two behaviours are hard to reach from the ports.

The dither phase is a hidden count of every sample since reset. The bench keeps its own count of all requests it has issued and derives the expected increment from that count.

The automatic gain step depends on the previous sample. To cover every pairing of starting gain and raw code, the bench writes the starting gain before each automatic sample. It then checks the gain that results.

// File: rtl/err_autorange.sv
module err_autorange #(
  parameter int RAW_W  = 6,
  parameter int REF_W  = 10,
  parameter int DITH_W = 4,
  localparam int WORD_W = REF_W + 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sample_req,
  input  logic [RAW_W-1:0]         raw_code,
  input  logic                     auto_en,
  input  logic                     gain_wr,
  input  logic [1:0]               gain_wdata,
  input  logic                     invert,
  input  logic                     abs_mode,
  input  logic [REF_W-1:0]         ref_int,
  input  logic [DITH_W-1:0]        ref_frac,
  output logic signed [WORD_W-1:0] err_word,
  output logic                     err_valid,
  output logic [1:0]               gain_cur
);

  localparam logic [RAW_W-1:0] CODE_MIN = {1'b1, {(RAW_W-1){1'b0}}};
  localparam logic [RAW_W-1:0] CODE_MAX = {1'b0, {(RAW_W-1){1'b1}}};
  localparam logic [RAW_W-1:0] HALF_NEG = {2'b11, {(RAW_W-2){1'b0}}};

  logic signed [WORD_W-1:0] raw_x, scaled, signed_err, setpt_x, result;
  logic [DITH_W-1:0] phase, phase_rev;
  logic [REF_W:0]    setpt;
  logic              bump, at_edge, is_small;
  logic [1:0]        gain_auto;

  assign raw_x      = {{(WORD_W-RAW_W){raw_code[RAW_W-1]}}, raw_code};
  assign scaled     = raw_x <<< (2'd3 - gain_cur);
  assign signed_err = invert ? -scaled : scaled;

  for (genvar i = 0; i < DITH_W; i++) begin : g_rev
    assign phase_rev[i] = phase[DITH_W-1-i];
  end

  assign bump    = phase_rev < ref_frac;
  assign setpt   = {1'b0, ref_int} + {{REF_W{1'b0}}, bump};
  assign setpt_x = {{(WORD_W-REF_W-1){1'b0}}, setpt};
  assign result  = abs_mode ? signed_err + setpt_x : signed_err;

  assign at_edge  = (raw_code == CODE_MIN) || (raw_code == CODE_MAX);
  assign is_small = (raw_code[RAW_W-1] == raw_code[RAW_W-2]) && (raw_code != HALF_NEG);

  always_comb begin
    gain_auto = gain_cur;
    if (at_edge && gain_cur != 2'd0)
      gain_auto = gain_cur - 2'd1;
    else if (is_small && gain_cur != 2'd3)
      gain_auto = gain_cur + 2'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_word  <= '0;
      err_valid <= 1'b0;
      gain_cur  <= 2'd0;
      phase     <= '0;
    end else begin
      err_valid <= sample_req;
      if (sample_req) begin
        err_word <= result;
        phase    <= phase + 1'b1;
        if (auto_en) gain_cur <= gain_auto;
      end
      if (gain_wr) gain_cur <= gain_wdata;
    end
  end

endmodule

// File: rtl/err_autorange_chk.sv
module err_autorange_chk #(
  parameter int REF_W = 10,
  localparam int WORD_W = REF_W + 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     sample_req,
  input logic                     auto_en,
  input logic                     gain_wr,
  input logic [1:0]               gain_wdata,
  input logic                     abs_mode,
  input logic signed [WORD_W-1:0] err_word,
  input logic                     err_valid,
  input logic [1:0]               gain_cur
);

  // R2
  strobe_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_req |=> err_valid);

  // R2
  word_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_req |=> (!err_valid && $stable(err_word)));

  // R4
  gain_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gain_wr |=> gain_cur == $past(gain_wdata));

  // R5
  gain_manual_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gain_wr && (!sample_req || !auto_en)) |=> $stable(gain_cur));

  // R6
  gain_single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_req && auto_en && !gain_wr) |=>
      (gain_cur == $past(gain_cur) || gain_cur == $past(gain_cur) + 2'd1 ||
       gain_cur == $past(gain_cur) - 2'd1));

  // R3
  err_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_req && !abs_mode) |=> (err_word >= -256 && err_word <= 256));

endmodule

bind err_autorange err_autorange_chk #(.REF_W(REF_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .sample_req(sample_req), .auto_en(auto_en),
  .gain_wr(gain_wr), .gain_wdata(gain_wdata), .abs_mode(abs_mode),
  .err_word(err_word), .err_valid(err_valid), .gain_cur(gain_cur)
);

// File: tb/err_autorange_test.sv
`timescale 1ns/1ps
module err_autorange_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sample_req = 1'b0, auto_en = 1'b0, gain_wr = 1'b0, invert = 1'b0, abs_mode = 1'b0;
  logic [5:0] raw_code = '0;
  logic [1:0] gain_wdata = '0;
  logic [9:0] ref_int = '0;
  logic [3:0] ref_frac = '0;
  logic signed [11:0] err_word;
  logic err_valid;
  logic [1:0] gain_cur;

  int checks = 0, errors = 0, nsamp = 0, gm = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  err_autorange uut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int rev4(input int n);
    return ((n & 1) << 3) | ((n & 2) << 1) | ((n & 4) >> 1) | ((n & 8) >> 3);
  endfunction

  task automatic wr_gain(input int g);
    @(negedge clk); gain_wr = 1'b1; gain_wdata = 2'(g);
    @(negedge clk); gain_wr = 1'b0;
    gm = g;
    chk(gain_cur == 2'(g), "R4", gain_cur, g);
  endtask

  task automatic do_sample(input int raw, input bit inv, input bit absm, input bit aut,
                           input int rf, input int fr, input string req);
    int exp, ph, got;
    exp = raw * (1 << (3 - gm));
    if (inv) exp = -exp;
    ph = nsamp % 16;
    if (absm) exp = exp + rf + ((rev4(ph) < fr) ? 1 : 0);
    if (aut) begin
      if ((raw == -32 || raw == 31) && gm > 0) gm = gm - 1;
      else if (raw >= -15 && raw <= 15 && gm < 3) gm = gm + 1;
    end
    nsamp++;
    @(negedge clk);
    raw_code = 6'(raw); invert = inv; abs_mode = absm; auto_en = aut;
    ref_int = 10'(rf); ref_frac = 4'(fr); sample_req = 1'b1;
    @(negedge clk); sample_req = 1'b0;
    got = err_word;
    chk(got == exp, req, got, exp);
    chk(err_valid == 1'b1, "R2", err_valid, 1);
    chk(gain_cur == 2'(gm), aut ? "R6" : "R5", gain_cur, gm);
  endtask

  initial begin
    int inc, w0, got;
    repeat (3) @(negedge clk);
    chk(err_word == 0, "R1", err_word, 0);
    chk(err_valid == 1'b0, "R1", err_valid, 0);
    chk(gain_cur == 2'd0, "R1", gain_cur, 0);
    rst_n = 1'b1;

    // R3 R7 R5: every gain, every code, both polarities
    for (int g = 0; g < 4; g++) begin
      wr_gain(g);
      for (int r = -32; r < 32; r++)
        for (int v = 0; v < 2; v++)
          do_sample(r, v[0], 1'b0, 1'b0, 0, 0, v[0] ? "R7" : "R3");
    end

    // R2: strobe drops and word holds without request
    w0 = err_word;
    @(negedge clk);
    chk(err_valid == 1'b0, "R2", err_valid, 0);
    got = err_word;
    chk(got == w0, "R2", got, w0);

    // R8 R9: dither over full frames for each fraction
    wr_gain(3);
    for (int f = 0; f < 16; f++) begin
      inc = 0;
      for (int k = 0; k < 16; k++) begin
        do_sample(0, 1'b0, 1'b1, 1'b0, 500, f, "R9");
        got = err_word;
        if (got == 501) inc++;
      end
      chk(inc == f, "R9", inc, f);
    end
    wr_gain(0);
    do_sample(31, 1'b0, 1'b1, 1'b0, 1023, 15, "R8");
    do_sample(-32, 1'b1, 1'b1, 1'b0, 1023, 15, "R8");
    do_sample(-32, 1'b0, 1'b1, 1'b0, 7, 0, "R8");

    // R6: every starting gain against every code
    for (int g = 0; g < 4; g++)
      for (int r = -32; r < 32; r++) begin
        wr_gain(g);
        do_sample(r, 1'b0, 1'b0, 1'b1, 0, 0, "R6");
      end
    // R6: climb and descent sequence
    wr_gain(0);
    for (int k = 0; k < 5; k++) do_sample(3, 1'b0, 1'b0, 1'b1, 0, 0, "R6");
    for (int k = 0; k < 5; k++) do_sample(-32, 1'b0, 1'b0, 1'b1, 0, 0, "R6");

    // R4: write wins over a simultaneous automatic update
    wr_gain(1);
    @(negedge clk);
    raw_code = 6'd2; auto_en = 1'b1; abs_mode = 1'b0; invert = 1'b0;
    sample_req = 1'b1; gain_wr = 1'b1; gain_wdata = 2'd0;
    nsamp++;
    @(negedge clk); sample_req = 1'b0; gain_wr = 1'b0; auto_en = 1'b0;
    chk(gain_cur == 2'd0, "R4", gain_cur, 0);
    got = err_word;
    chk(got == 8, "R3", got, 8);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule